// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the memory address for a data operand of a 16-bit segmented processor. From a mode code, a base-register select, an index-register select, the current contents of the pointer registers (BX, BP, SI, DI), the three data-side segment registers (DS, SS, ES) and a displacement, it builds a 16-bit offset. It then adds the segment value shifted left by four bits to give a 20-bit physical address.

The segment is never named by the caller. It follows from the operands: a BP base selects the stack segment, the string-destination form selects the extra segment, and every other form selects the data segment. The caller pulses `req_i` with the operands applied. One cycle later `valid_o` is high for exactly one cycle, and the offset, the physical address and the chosen segment code stand on the outputs. They stay there until the next request.

Top module: `seg_ea_gen`

## Requirements
- R1: `phys_o` equals (segment value × 16 + `offset_o`) modulo 2^20, where the segment value is DS, SS or ES as given by R4.
- R2: `mode_i` selects the terms added into the offset. 0 = displacement only. 1 = base only. 2 = index only. 3 = base + displacement. 4 = index + displacement. 5 = base + index. 6 = base + index + displacement. 7 = DI only (string destination).
- R3: `base_sel_i` = 0 picks BX and 1 picks BP. `index_sel_i` = 0 picks SI and 1 picks DI. A select has no effect in a mode that does not use its term, and `index_sel_i` has no effect in mode 7.
- R4: `seg_sel_o` is 1 (SS) when the mode uses a base and the base is BP. It is 2 (ES) in mode 7. It is 0 (DS) in every other case, including index-only and direct forms.
- R5: With `disp_wide_i` = 0, only `disp_i[7:0]` is used, sign-extended to 16 bits, and `disp_i[15:8]` is ignored. With `disp_wide_i` = 1, all 16 bits are used. Mode 0 always uses all 16 bits.
- R6: The offset sum wraps modulo 2^16. No carry passes into the segment part.
- R7: `valid_o` is high in exactly the cycle after a cycle with `req_i` high. The results of that request appear in the same cycle.
- R8: In a cycle after `req_i` was low, `valid_o` is low and `offset_o`, `phys_o` and `seg_sel_o` keep their values.
- R9: While `rst_ni` is low, all outputs are zero.
- R10: A physical address above FFFFFh wraps, so segment FFFFh with offset 0010h gives 00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request: compute from the present inputs |
| mode_i | input | 3 | Addressing form code (R2) |
| base_sel_i | input | 1 | 0 = BX, 1 = BP |
| index_sel_i | input | 1 | 0 = SI, 1 = DI |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = sign-extended low byte |
| disp_i | input | 16 | Displacement |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| es_i | input | 16 | Extra segment value |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| valid_o | output | 1 | One-cycle result strobe |
| offset_o | output | 16 | Effective offset |
| phys_o | output | 20 | Physical address |
| seg_sel_o | output | 2 | Segment used: 0 DS, 1 SS, 2 ES |

## Verification
The bench targets negative 8-bit displacements whose upper byte holds garbage. A design that ignored the width flag, or zero-extended the byte, would produce an offset off by 256 or by 65536 minus the magnitude. BP-based forms are checked next to BX-based and index-only forms with distinct DS and SS values. A design that keyed the stack segment on any pointer, or on the index, would therefore produce the wrong physical address.

Offset and physical wrap-around are driven separately. A carry leaking from the offset into the segment part shows up as a 64 KiB error. The directed cases also include idle stretches with changing inputs, which expose outputs that are not held between requests.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

  typedef enum logic [2:0] {
    MODE_DIRECT          = 3'd0,
    MODE_IND_BASE        = 3'd1,
    MODE_IND_INDEX       = 3'd2,
    MODE_BASED           = 3'd3,
    MODE_INDEXED         = 3'd4,
    MODE_BASE_INDEX      = 3'd5,
    MODE_BASE_INDEX_DISP = 3'd6,
    MODE_STR_DST         = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    SEG_DS = 2'd0,
    SEG_SS = 2'd1,
    SEG_ES = 2'd2
  } seg_code_e;

  function automatic logic mode_has_base(ea_mode_e m);
    return (m == MODE_IND_BASE) || (m == MODE_BASED) ||
           (m == MODE_BASE_INDEX) || (m == MODE_BASE_INDEX_DISP);
  endfunction

  function automatic logic mode_has_index(ea_mode_e m);
    return (m == MODE_IND_INDEX) || (m == MODE_INDEXED) ||
           (m == MODE_BASE_INDEX) || (m == MODE_BASE_INDEX_DISP) ||
           (m == MODE_STR_DST);
  endfunction

  function automatic logic mode_has_disp(ea_mode_e m);
    return (m == MODE_DIRECT) || (m == MODE_BASED) ||
           (m == MODE_INDEXED) || (m == MODE_BASE_INDEX_DISP);
  endfunction

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int OFS_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic [OFS_W-1:0] disp_i,
  input  logic             wide_i,
  output logic [OFS_W-1:0] disp_o
);
  localparam int EXT_W = OFS_W - NARROW_W;

  logic [OFS_W-1:0] narrow_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign narrow_ext = {{EXT_W{disp_i[NARROW_W-1]}}, disp_i[NARROW_W-1:0]};
    end else begin : g_noext
      assign narrow_ext = disp_i;
    end
  endgenerate

  assign disp_o = wide_i ? disp_i : narrow_ext;
endmodule

// File: rtl/ea_term_sel.sv
module ea_term_sel
  import seg_ea_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  ea_mode_e         mode_i,
  input  logic             base_sel_i,
  input  logic             index_sel_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] disp_i,
  output logic [OFS_W-1:0] base_o,
  output logic [OFS_W-1:0] index_o,
  output logic [OFS_W-1:0] disp_o,
  output logic             base_is_bp_o
);
  logic [OFS_W-1:0] base_raw, index_raw;

  always_comb begin
    base_raw  = base_sel_i ? bp_i : bx_i;
    // string destination is tied to DI
    if (mode_i == MODE_STR_DST) index_raw = di_i;
    else                        index_raw = index_sel_i ? di_i : si_i;
  end

  assign base_o       = mode_has_base(mode_i)  ? base_raw  : '0;
  assign index_o      = mode_has_index(mode_i) ? index_raw : '0;
  assign disp_o       = mode_has_disp(mode_i)  ? disp_i    : '0;
  assign base_is_bp_o = mode_has_base(mode_i) & base_sel_i;
endmodule

// File: rtl/ea_seg_sel.sv
module ea_seg_sel
  import seg_ea_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  ea_mode_e         mode_i,
  input  logic             base_is_bp_i,
  input  logic [SEG_W-1:0] ds_i,
  input  logic [SEG_W-1:0] ss_i,
  input  logic [SEG_W-1:0] es_i,
  output logic [SEG_W-1:0] seg_o,
  output seg_code_e        code_o
);
  always_comb begin
    if (mode_i == MODE_STR_DST) begin
      code_o = SEG_ES;
      seg_o  = es_i;
    end else if (base_is_bp_i) begin
      code_o = SEG_SS;
      seg_o  = ss_i;
    end else begin
      code_o = SEG_DS;
      seg_o  = ds_i;
    end
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic [OFS_W-1:0]  base_i,
  input  logic [OFS_W-1:0]  index_i,
  input  logic [OFS_W-1:0]  disp_i,
  input  logic [OFS_W-1:0]  seg_i,
  output logic [OFS_W-1:0]  offset_o,
  output logic [PHYS_W-1:0] phys_o
);
  logic [PHYS_W-1:0] seg_shifted, ofs_ext;

  // offset wraps at OFS_W bits before the segment is added
  assign offset_o    = base_i + index_i + disp_i;
  assign seg_shifted = {seg_i, {SEG_SHIFT{1'b0}}};
  assign ofs_ext     = {{SEG_SHIFT{1'b0}}, offset_o};
  assign phys_o      = seg_shifted + ofs_ext;
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NARROW_W  = 8,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        mode_i,
  input  logic              base_sel_i,
  input  logic              index_sel_i,
  input  logic              disp_wide_i,
  input  logic [OFS_W-1:0]  disp_i,
  input  logic [OFS_W-1:0]  ds_i,
  input  logic [OFS_W-1:0]  ss_i,
  input  logic [OFS_W-1:0]  es_i,
  input  logic [OFS_W-1:0]  bx_i,
  input  logic [OFS_W-1:0]  bp_i,
  input  logic [OFS_W-1:0]  si_i,
  input  logic [OFS_W-1:0]  di_i,
  output logic              valid_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic [PHYS_W-1:0] phys_o,
  output logic [1:0]        seg_sel_o
);
  ea_mode_e          mode;
  logic              wide_eff;
  logic [OFS_W-1:0]  disp_ext;
  logic [OFS_W-1:0]  base_t, index_t, disp_t, seg_val;
  logic              base_is_bp;
  seg_code_e         seg_code;
  logic [OFS_W-1:0]  offset_d;
  logic [PHYS_W-1:0] phys_d;

  assign mode     = ea_mode_e'(mode_i);
  assign wide_eff = disp_wide_i | (mode == MODE_DIRECT);

  ea_disp_ext #(.OFS_W(OFS_W), .NARROW_W(NARROW_W)) u_disp (
    .disp_i (disp_i),
    .wide_i (wide_eff),
    .disp_o (disp_ext)
  );

  ea_term_sel #(.OFS_W(OFS_W)) u_terms (
    .mode_i       (mode),
    .base_sel_i   (base_sel_i),
    .index_sel_i  (index_sel_i),
    .bx_i         (bx_i),
    .bp_i         (bp_i),
    .si_i         (si_i),
    .di_i         (di_i),
    .disp_i       (disp_ext),
    .base_o       (base_t),
    .index_o      (index_t),
    .disp_o       (disp_t),
    .base_is_bp_o (base_is_bp)
  );

  ea_seg_sel #(.SEG_W(OFS_W)) u_seg (
    .mode_i       (mode),
    .base_is_bp_i (base_is_bp),
    .ds_i         (ds_i),
    .ss_i         (ss_i),
    .es_i         (es_i),
    .seg_o        (seg_val),
    .code_o       (seg_code)
  );

  ea_sum #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_sum (
    .base_i   (base_t),
    .index_i  (index_t),
    .disp_i   (disp_t),
    .seg_i    (seg_val),
    .offset_o (offset_d),
    .phys_o   (phys_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      offset_o  <= '0;
      phys_o    <= '0;
      seg_sel_o <= 2'd0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        offset_o  <= offset_d;
        phys_o    <= phys_d;
        seg_sel_o <= seg_code;
      end
    end
  end

  assert_valid_after_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  assert_idle_no_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);

  assert_hold_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(offset_o) && $stable(phys_o) && $stable(seg_sel_o)));

  assert_low_bits_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (phys_o[SEG_SHIFT-1:0] == offset_o[SEG_SHIFT-1:0]));

  assert_string_dst_es_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == MODE_STR_DST) |=> (seg_sel_o == SEG_ES));

  assert_bp_base_ss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && base_sel_i && mode_has_base(ea_mode_e'(mode_i))) |=> (seg_sel_o == SEG_SS));

  assert_direct_full_disp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == MODE_DIRECT) |=> (offset_o == $past(disp_i)));
endmodule

// File: tb/seg_ea_gen_test.sv
`timescale 1ns/1ps
module seg_ea_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        base_sel_i = 1'b0, index_sel_i = 1'b0, disp_wide_i = 1'b0;
  logic [15:0] disp_i = '0, ds_i = '0, ss_i = '0, es_i = '0;
  logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
  logic        valid_o;
  logic [15:0] offset_o;
  logic [19:0] phys_o;
  logic [1:0]  seg_sel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk_i = ~clk_i;

  seg_ea_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .mode_i(mode_i),
    .base_sel_i(base_sel_i), .index_sel_i(index_sel_i), .disp_wide_i(disp_wide_i),
    .disp_i(disp_i), .ds_i(ds_i), .ss_i(ss_i), .es_i(es_i),
    .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
    .valid_o(valid_o), .offset_o(offset_o), .phys_o(phys_o), .seg_sel_o(seg_sel_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_regs(logic [15:0] ds, logic [15:0] ss, logic [15:0] es,
                          logic [15:0] bx, logic [15:0] bp, logic [15:0] si, logic [15:0] di);
    ds_i = ds; ss_i = ss; es_i = es; bx_i = bx; bp_i = bp; si_i = si; di_i = di;
  endtask

  // apply one request at a falling edge, sample 1 ns after the capturing edge
  task automatic run_case(string req, logic [2:0] mode, logic bsel, logic isel,
                          logic [15:0] disp, logic wide,
                          logic [15:0] exp_ofs, logic [19:0] exp_phys, logic [1:0] exp_seg);
    @(negedge clk_i);
    mode_i = mode; base_sel_i = bsel; index_sel_i = isel;
    disp_i = disp; disp_wide_i = wide; req_i = 1'b1;
    @(posedge clk_i); #1;
    check(req, "valid", {31'd0, valid_o}, 32'd1);
    check(req, "offset", {16'd0, offset_o}, {16'd0, exp_ofs});
    check(req, "phys", {12'd0, phys_o}, {12'd0, exp_phys});
    check(req, "seg", {30'd0, seg_sel_o}, {30'd0, exp_seg});
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R9", "valid", {31'd0, valid_o}, 32'd0);
    check("R9", "offset", {16'd0, offset_o}, 32'd0);
    check("R9", "phys", {12'd0, phys_o}, 32'd0);
    check("R9", "seg", {30'd0, seg_sel_o}, 32'd0);
  endtask

  task automatic t_direct;
    set_regs(16'h1000, 16'h5555, 16'h6666, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    run_case("R1", 3'd0, 1'b1, 1'b1, 16'h7000, 1'b1, 16'h7000, 20'h17000, 2'd0);
    // R5: direct mode ignores the width flag
    run_case("R5", 3'd0, 1'b0, 1'b0, 16'h12F0, 1'b0, 16'h12F0, 20'h112F0, 2'd0);
  endtask

  task automatic t_indirect;
    set_regs(16'h0800, 16'h0900, 16'h0000, 16'h0050, 16'h2000, 16'h2000, 16'h0040);
    run_case("R2", 3'd2, 1'b0, 1'b0, 16'hFFFF, 1'b1, 16'h2000, 20'h0A000, 2'd0);
    run_case("R3", 3'd2, 1'b1, 1'b1, 16'h0000, 1'b1, 16'h0040, 20'h08040, 2'd0);
    run_case("R4", 3'd1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h2000, 20'h0B000, 2'd1);
    run_case("R3", 3'd1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0050, 20'h08050, 2'd0);
  endtask

  task automatic t_based_indexed;
    set_regs(16'h0100, 16'h0A00, 16'h0000, 16'h0600, 16'h0012, 16'h0000, 16'h0000);
    run_case("R2", 3'd3, 1'b0, 1'b0, 16'h0004, 1'b0, 16'h0604, 20'h01604, 2'd0);
    // BP-7 as 8-bit displacement with junk in the upper byte
    run_case("R5", 3'd3, 1'b1, 1'b0, 16'hABF9, 1'b0, 16'h000B, 20'h0A00B, 2'd1);
    set_regs(16'h0200, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0030);
    run_case("R5", 3'd4, 1'b0, 1'b1, 16'h00F8, 1'b0, 16'h0028, 20'h02028, 2'd0);
    run_case("R5", 3'd4, 1'b0, 1'b1, 16'h00F8, 1'b1, 16'h0128, 20'h02128, 2'd0);
  endtask

  task automatic t_base_index;
    set_regs(16'h0B00, 16'h2000, 16'h0000, 16'h0112, 16'h4000, 16'h0800, 16'h0003);
    run_case("R2", 3'd5, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h4800, 20'h24800, 2'd1);
    run_case("R4", 3'd5, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0115, 20'h0B115, 2'd0);
    set_regs(16'h0300, 16'h1100, 16'h0000, 16'h1000, 16'h0110, 16'h000A, 16'h0010);
    run_case("R2", 3'd6, 1'b0, 1'b1, 16'h2080, 1'b1, 16'h3090, 20'h06090, 2'd0);
    run_case("R2", 3'd6, 1'b1, 1'b0, 16'h0010, 1'b1, 16'h012A, 20'h1112A, 2'd1);
  endtask

  task automatic t_string_dst;
    set_regs(16'h0510, 16'h0700, 16'h0300, 16'h0000, 16'h0000, 16'h0999, 16'h0100);
    // R3: index_sel set to SI has no effect in mode 7
    run_case("R4", 3'd7, 1'b1, 1'b0, 16'h0044, 1'b1, 16'h0100, 20'h03100, 2'd2);
  endtask

  task automatic t_wrap;
    set_regs(16'h0000, 16'h0000, 16'h0000, 16'hFFF0, 16'h0000, 16'h0020, 16'h0000);
    run_case("R6", 3'd5, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0010, 20'h00010, 2'd0);
    run_case("R6", 3'd3, 1'b0, 1'b0, 16'h0080, 1'b0, 16'hFF70, 20'h0FF70, 2'd0);
    set_regs(16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    run_case("R10", 3'd0, 1'b0, 1'b0, 16'h0010, 1'b1, 16'h0010, 20'h00000, 2'd0);
    run_case("R10", 3'd0, 1'b0, 1'b0, 16'h0025, 1'b1, 16'h0025, 20'h00015, 2'd0);
  endtask

  task automatic t_hold;
    set_regs(16'h1234, 16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000);
    run_case("R7", 3'd1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0001, 20'h12341, 2'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      mode_i = 3'd7; es_i = 16'hAAAA + 16'(i); di_i = 16'h5555; bx_i = 16'h7777;
      @(posedge clk_i); #1;
      check("R8", "valid idle", {31'd0, valid_o}, 32'd0);
      check("R8", "offset held", {16'd0, offset_o}, 32'h0001);
      check("R8", "phys held", {12'd0, phys_o}, 32'h12341);
      check("R8", "seg held", {30'd0, seg_sel_o}, 32'd0);
    end
  endtask

  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_direct();
    t_indirect();
    t_based_indexed();
    t_base_index();
    t_string_dst();
    t_wrap();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule